// File: doc/BRIEF.md
# Endpoint Buffer Event Interrupt Unit

This block turns the event strobes of a USB device's packet engine and DMA engine into per-endpoint interrupt status for six endpoints, numbered 0 to 5. It keeps three status vectors, one bit per endpoint in each:
- drained-or-oversize,
- not-ready,
- ready.

Each vector has its own enable mask. A single interrupt line is asserted while any enabled status bit is pending. Software acknowledges a status bit by writing a one to its clear input.

What raises a bit depends on four things about the endpoint: its direction, its transfer type, its buffering (single or double) and whether the CPU or DMA services it. Endpoint 0 follows its own rules. It reports ready only for its receive side. In continuous-receive mode it reports ready after a running byte total reaches a threshold, or when a short packet arrives. Isochronous endpoints report underrun and overrun at token end, and report CRC-damaged OUT data at transaction end.

All status bits are registered. An event sampled on a rising edge is visible in the status vector after that edge.

Top module: `epbuf_irq_unit`

## Requirements
- R1: After a synchronous active-low reset, all three status vectors read zero and `irq` is low.
- R2: For an IN endpoint, the drained bit sets when a drain strobe empties the last filled buffer half. With `cfg_dbl` set, both filled halves must be drained before the bit sets. A drain that leaves one half filled does not set it.
- R3: For an OUT endpoint, the oversize bit (same vector as R2) sets at transaction end when `rx_len` is strictly greater than that endpoint's maximum packet size. A length equal to the maximum does not set it.
- R4: For a non-isochronous endpoint, the not-ready bit sets at token end when `tok_buf_rdy` is low. It stays clear when `tok_buf_rdy` is high.
- R5: For an isochronous endpoint, selected by transfer type encoding 2'b10, the not-ready bit follows two rules. It sets at token end when `tok_xrun` is high, and it ignores `tok_buf_rdy`. It also sets at the end of an OUT transaction that carries a CRC error.
- R6: On endpoint 0, `buf_rdy_evt[0]` sets the ready bit only while `cfg_dir_in[0]` is 0, meaning the receive side. While that bit is 1 (transmit side), the strobe has no effect.
- R7: In endpoint 0 continuous-receive mode, selected by `ep0_cont_rx`=1 with `cfg_dir_in[0]`=0, the ready bit sets at the transaction that brings the running received byte total to 255 or more. It also sets at any short packet. The total then restarts from zero, and `buf_rdy_evt[0]` is ignored in this mode.
- R8: On endpoints 1 to 5 with CPU access (`cfg_dma` bit 0), `buf_rdy_evt` sets the ready bit.
- R9: On endpoints 1 to 5 with DMA access, the ready bit sets for an OUT endpoint on a `dma_done` strobe, but only when a short packet was received on a strictly earlier cycle and no `dma_done` has come since. With DMA access and IN direction, the ready bit never sets.
- R10: Status bits are write-1-to-clear through the `clr_*` inputs. A set event in the same cycle as a clear leaves the bit set.
- R11: `irq` is high exactly when some status bit is set whose matching enable bit is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dir_in | input | 6 | Per endpoint: 1 = IN (device to host); for endpoint 0, the current data direction |
| cfg_xfer_type | input | 12 | Two bits per endpoint: 00 bulk, 01 interrupt, 10 isochronous, 11 treated as bulk |
| cfg_dbl | input | 6 | Per endpoint: 1 = two buffer halves |
| cfg_dma | input | 6 | Per endpoint 1..5: 1 = serviced by DMA (ignored on endpoint 0) |
| cfg_maxpkt | input | 66 | Eleven-bit maximum packet size per endpoint, endpoint 0 in the low bits |
| ep0_cont_rx | input | 1 | Endpoint 0 continuous-receive mode |
| tok_end | input | 1 | Strobe: token reception finished |
| tok_ep | input | 3 | Endpoint addressed by the token |
| tok_buf_rdy | input | 1 | Buffer was ready when the token ended |
| tok_xrun | input | 1 | Isochronous overrun or underrun at the token |
| xact_end | input | 1 | Strobe: data transaction finished |
| xact_ep | input | 3 | Endpoint of the transaction |
| rx_len | input | 11 | Received data packet length in bytes |
| rx_short | input | 1 | Received packet was short |
| rx_crc_err | input | 1 | Received packet had a CRC error |
| buf_fill | input | 6 | Strobe per endpoint: one buffer half committed for sending |
| buf_drain | input | 6 | Strobe per endpoint: one buffer half fully sent |
| buf_rdy_evt | input | 6 | Strobe per endpoint: buffer became accessible |
| dma_done | input | 6 | Strobe per endpoint: DMA transfer ended |
| en_emp | input | 6 | Enable mask, drained/oversize vector |
| en_nrdy | input | 6 | Enable mask, not-ready vector |
| en_rdy | input | 6 | Enable mask, ready vector |
| clr_emp | input | 6 | Write-1-to-clear, drained/oversize vector |
| clr_nrdy | input | 6 | Write-1-to-clear, not-ready vector |
| clr_rdy | input | 6 | Write-1-to-clear, ready vector |
| st_emp | output | 6 | Drained/oversize status |
| st_nrdy | output | 6 | Not-ready status |
| st_rdy | output | 6 | Ready status |
| irq | output | 1 | Any enabled status pending |

## Verification
A set event and a software clear of the same status bit can arrive in the same cycle. The bench provokes this by raising `buf_rdy_evt` for an endpoint together with its `clr_rdy` bit while the bit is already pending. It then confirms that the bit reads set afterwards, and that a clear issued alone then drops it. A second collision is between a DMA-done strobe and the short packet it depends on: a `dma_done` given before any short packet must leave the ready bit clear, and only a later `dma_done` may set it.

// File: rtl/epbuf_pkg.sv
// Shared encodings for the endpoint buffer event interrupt unit.
// Assumes: two-bit transfer-type field per endpoint; reserved code acts as bulk.
package epbuf_pkg;

    typedef enum logic [1:0] {
        XT_BULK = 2'b00,
        XT_INTR = 2'b01,
        XT_ISO  = 2'b10,
        XT_RSVD = 2'b11
    } xfer_type_e;

    // Per-endpoint set strobes toward the three status vectors.
    typedef struct packed {
        logic emp;
        logic nrdy;
        logic rdy;
    } ep_evt_t;

endpackage

// File: rtl/epbuf_w1c_vec.sv
// Write-1-to-clear status vector.
// What: holds one sticky bit per endpoint, set by event strobes and cleared by software.
// Assumes: set wins over clear in the same cycle; synchronous active-low reset.
module epbuf_w1c_vec #(
    parameter int WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set,
    input  logic [WIDTH-1:0] clr,
    output logic [WIDTH-1:0] q
);

    // Sticky status update: clear first, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= (q & ~clr) | set;
        end
    end

    // R10: an event always leaves its bit set, even against a clear.
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((q & $past(set)) == $past(set)));

    // R10: a clear with no event drops the bit.
    a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr & ~set)) |=> ((q & $past(clr & ~set)) == '0));

endmodule

// File: rtl/epbuf_cont_rx.sv
// Endpoint 0 continuous-receive byte accumulator.
// What: sums good received packet lengths and raises a hit when the total reaches
//       the threshold or a short packet arrives; the total then restarts.
// Assumes: LIMIT fits in LEN_W bits; CRC-damaged packets are not counted.
module epbuf_cont_rx #(
    parameter int LEN_W = 11,
    parameter int LIMIT = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             xact_hit,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             rx_short,
    input  logic             rx_crc_err,
    output logic             hit
);

    localparam int SUM_W = LEN_W + 1;

    logic [SUM_W-1:0] acc_q;
    logic [SUM_W-1:0] sum;
    logic             good;

    // Candidate total and threshold decision for the current transaction.
    always_comb begin
        good = enable && xact_hit && !rx_crc_err;
        sum  = acc_q + SUM_W'(rx_len);
        hit  = good && (rx_short || (sum >= SUM_W'(LIMIT)));
    end

    // Running total: restart on hit or when the mode is off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (!enable || hit) begin
            acc_q <= '0;
        end else if (good) begin
            acc_q <= sum;
        end
    end

    // R7: the stored total never reaches the threshold.
    a_r7_acc_below_limit: assert property (@(posedge clk) disable iff (!rst_n)
        acc_q < SUM_W'(LIMIT));

endmodule

// File: rtl/epbuf_ep_cause.sv
// Per-endpoint interrupt cause decoder.
// What: converts packet-engine and DMA strobes aimed at one endpoint into set strobes
//       for the drained/oversize, not-ready and ready status bits, according to the
//       endpoint's direction, type, buffering and access mode.
// Assumes: configuration is stable while traffic is active; for endpoint 0 the
//          direction input tracks the current data stage, and DMA / isochronous
//          settings are ignored.
module epbuf_ep_cause
    import epbuf_pkg::*;
#(
    parameter int LEN_W  = 11,
    parameter bit IS_EP0 = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_in,
    input  logic [1:0]       xtype,
    input  logic             dbl,
    input  logic             dma,
    input  logic [LEN_W-1:0] maxpkt,
    input  logic             tok_hit,
    input  logic             tok_buf_rdy,
    input  logic             tok_xrun,
    input  logic             xact_hit,
    input  logic [LEN_W-1:0] rx_len,
    input  logic             rx_short,
    input  logic             rx_crc_err,
    input  logic             fill,
    input  logic             drain,
    input  logic             rdy_evt,
    input  logic             dma_done,
    input  logic             cont_en,
    input  logic             cont_hit,
    output ep_evt_t          evt
);

    logic       is_iso;
    logic       use_dma;
    logic [1:0] cap;
    logic [1:0] occ_q;
    logic       fill_ok;
    logic       drain_ok;
    logic       armed_q;
    logic       arm_set;
    logic       drained;
    logic       oversize;

    // Effective mode bits; endpoint 0 is never isochronous nor DMA-serviced.
    always_comb begin
        is_iso  = IS_EP0 ? 1'b0 : (xtype == XT_ISO);
        use_dma = IS_EP0 ? 1'b0 : dma;
        cap     = dbl ? 2'd2 : 2'd1;
    end

    // Filled-half bookkeeping qualifiers: no fill past capacity, no drain below zero.
    always_comb begin
        fill_ok  = fill && (occ_q < cap);
        drain_ok = drain && (occ_q != 2'd0);
    end

    // Count of buffer halves holding data not yet sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= 2'd0;
        end else if (fill_ok && !drain_ok) begin
            occ_q <= occ_q + 2'd1;
        end else if (drain_ok && !fill_ok) begin
            occ_q <= occ_q - 2'd1;
        end
    end

    // Short-packet arm for DMA OUT: set by a short packet, consumed by DMA done.
    always_comb begin
        arm_set = xact_hit && rx_short && !dir_in && use_dma;
    end

    // Arm register; a new short packet outranks a simultaneous consume.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (arm_set) begin
            armed_q <= 1'b1;
        end else if (dma_done) begin
            armed_q <= 1'b0;
        end
    end

    // Drained (IN) and oversize (OUT) causes.
    always_comb begin
        drained  = dir_in && drain_ok && !fill_ok && (occ_q == 2'd1);
        oversize = xact_hit && !dir_in && (rx_len > maxpkt);
    end

    // Assemble the three set strobes for this endpoint.
    always_comb begin
        evt.emp  = drained || oversize;
        evt.nrdy = (tok_hit && (is_iso ? tok_xrun : !tok_buf_rdy))
                || (xact_hit && is_iso && !dir_in && rx_crc_err);
        if (IS_EP0) begin
            evt.rdy = cont_en ? cont_hit : (rdy_evt && !dir_in);
        end else if (use_dma) begin
            evt.rdy = dma_done && armed_q && !dir_in;
        end else begin
            evt.rdy = rdy_evt;
        end
    end

    // R2: a lone drain on a nonempty buffer removes exactly one half.
    a_r2_drain_steps_down: assert property (@(posedge clk) disable iff (!rst_n)
        (drain && !fill && occ_q != 2'd0) |=> (occ_q == $past(occ_q) - 2'd1));

    // R2: the filled-half count never exceeds two.
    a_r2_occ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= 2'd2);

    // R9: the arm only drops after a DMA done.
    a_r9_arm_consumed_by_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(armed_q) |-> $past(dma_done));

endmodule

// File: rtl/epbuf_irq_unit.sv
// Endpoint buffer event interrupt unit (top).
// What: routes token/transaction strobes to per-endpoint cause decoders, keeps the
//       three write-1-to-clear status vectors and drives one masked interrupt line.
// Assumes: at most one token end and one transaction end per cycle; endpoint
//          numbers at or above NUM_EP are ignored.
module epbuf_irq_unit
    import epbuf_pkg::*;
#(
    parameter int NUM_EP = 6,
    parameter int LEN_W  = 11,
    parameter int LIMIT  = 255,
    localparam int EP_W  = $clog2(NUM_EP)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_EP-1:0]       cfg_dir_in,
    input  logic [2*NUM_EP-1:0]     cfg_xfer_type,
    input  logic [NUM_EP-1:0]       cfg_dbl,
    input  logic [NUM_EP-1:0]       cfg_dma,
    input  logic [NUM_EP*LEN_W-1:0] cfg_maxpkt,
    input  logic                    ep0_cont_rx,
    input  logic                    tok_end,
    input  logic [EP_W-1:0]         tok_ep,
    input  logic                    tok_buf_rdy,
    input  logic                    tok_xrun,
    input  logic                    xact_end,
    input  logic [EP_W-1:0]         xact_ep,
    input  logic [LEN_W-1:0]        rx_len,
    input  logic                    rx_short,
    input  logic                    rx_crc_err,
    input  logic [NUM_EP-1:0]       buf_fill,
    input  logic [NUM_EP-1:0]       buf_drain,
    input  logic [NUM_EP-1:0]       buf_rdy_evt,
    input  logic [NUM_EP-1:0]       dma_done,
    input  logic [NUM_EP-1:0]       en_emp,
    input  logic [NUM_EP-1:0]       en_nrdy,
    input  logic [NUM_EP-1:0]       en_rdy,
    input  logic [NUM_EP-1:0]       clr_emp,
    input  logic [NUM_EP-1:0]       clr_nrdy,
    input  logic [NUM_EP-1:0]       clr_rdy,
    output logic [NUM_EP-1:0]       st_emp,
    output logic [NUM_EP-1:0]       st_nrdy,
    output logic [NUM_EP-1:0]       st_rdy,
    output logic                    irq
);

    logic [NUM_EP-1:0] tok_hit;
    logic [NUM_EP-1:0] xact_hit;
    logic [NUM_EP-1:0] set_emp;
    logic [NUM_EP-1:0] set_nrdy;
    logic [NUM_EP-1:0] set_rdy;
    ep_evt_t           ev [NUM_EP];
    logic              cont_en;
    logic              cont_hit;

    // Endpoint 0 continuous-receive mode applies only on the receive side.
    always_comb begin
        cont_en = ep0_cont_rx && !cfg_dir_in[0];
    end

    epbuf_cont_rx #(
        .LEN_W (LEN_W),
        .LIMIT (LIMIT)
    ) u_cont_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (cont_en),
        .xact_hit   (xact_hit[0]),
        .rx_len     (rx_len),
        .rx_short   (rx_short),
        .rx_crc_err (rx_crc_err),
        .hit        (cont_hit)
    );

    for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
        // Endpoint address decode for this endpoint.
        always_comb begin
            tok_hit[i]  = tok_end  && (tok_ep  == EP_W'(i));
            xact_hit[i] = xact_end && (xact_ep == EP_W'(i));
        end

        epbuf_ep_cause #(
            .LEN_W  (LEN_W),
            .IS_EP0 (i == 0)
        ) u_cause (
            .clk         (clk),
            .rst_n       (rst_n),
            .dir_in      (cfg_dir_in[i]),
            .xtype       (cfg_xfer_type[2*i +: 2]),
            .dbl         (cfg_dbl[i]),
            .dma         (cfg_dma[i]),
            .maxpkt      (cfg_maxpkt[i*LEN_W +: LEN_W]),
            .tok_hit     (tok_hit[i]),
            .tok_buf_rdy (tok_buf_rdy),
            .tok_xrun    (tok_xrun),
            .xact_hit    (xact_hit[i]),
            .rx_len      (rx_len),
            .rx_short    (rx_short),
            .rx_crc_err  (rx_crc_err),
            .fill        (buf_fill[i]),
            .drain       (buf_drain[i]),
            .rdy_evt     (buf_rdy_evt[i]),
            .dma_done    (dma_done[i]),
            .cont_en     ((i == 0) ? cont_en  : 1'b0),
            .cont_hit    ((i == 0) ? cont_hit : 1'b0),
            .evt         (ev[i])
        );

        // Split the endpoint's strobes into the three set vectors.
        always_comb begin
            set_emp[i]  = ev[i].emp;
            set_nrdy[i] = ev[i].nrdy;
            set_rdy[i]  = ev[i].rdy;
        end
    end

    epbuf_w1c_vec #(.WIDTH(NUM_EP)) u_st_emp (
        .clk (clk), .rst_n (rst_n), .set (set_emp),  .clr (clr_emp),  .q (st_emp)
    );

    epbuf_w1c_vec #(.WIDTH(NUM_EP)) u_st_nrdy (
        .clk (clk), .rst_n (rst_n), .set (set_nrdy), .clr (clr_nrdy), .q (st_nrdy)
    );

    epbuf_w1c_vec #(.WIDTH(NUM_EP)) u_st_rdy (
        .clk (clk), .rst_n (rst_n), .set (set_rdy),  .clr (clr_rdy),  .q (st_rdy)
    );

    // Summary line: any enabled pending bit.
    always_comb begin
        irq = |((st_emp & en_emp) | (st_nrdy & en_nrdy) | (st_rdy & en_rdy));
    end

    // R11: with every mask closed the line stays low.
    a_r11_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((en_emp == '0) && (en_nrdy == '0) && (en_rdy == '0)) |-> !irq);

    // R1: the cycle after reset all status is clear.
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> ((st_emp == '0) && (st_nrdy == '0) && (st_rdy == '0)));

endmodule

// File: tb/test_epbuf_irq_unit.sv
// Directed bench for epbuf_irq_unit: one task per scenario, each checking itself.
module test_epbuf_irq_unit;

    localparam int NUM_EP = 6;
    localparam int LEN_W  = 11;

    logic                    clk = 1'b0;
    logic                    rst_n;
    logic [NUM_EP-1:0]       cfg_dir_in;
    logic [2*NUM_EP-1:0]     cfg_xfer_type;
    logic [NUM_EP-1:0]       cfg_dbl;
    logic [NUM_EP-1:0]       cfg_dma;
    logic [NUM_EP*LEN_W-1:0] cfg_maxpkt;
    logic                    ep0_cont_rx;
    logic                    tok_end;
    logic [2:0]              tok_ep;
    logic                    tok_buf_rdy;
    logic                    tok_xrun;
    logic                    xact_end;
    logic [2:0]              xact_ep;
    logic [LEN_W-1:0]        rx_len;
    logic                    rx_short;
    logic                    rx_crc_err;
    logic [NUM_EP-1:0]       buf_fill, buf_drain, buf_rdy_evt, dma_done;
    logic [NUM_EP-1:0]       en_emp, en_nrdy, en_rdy;
    logic [NUM_EP-1:0]       clr_emp, clr_nrdy, clr_rdy;
    logic [NUM_EP-1:0]       st_emp, st_nrdy, st_rdy;
    logic                    irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    epbuf_irq_unit i_epbuf_irq_unit (
        .clk (clk), .rst_n (rst_n),
        .cfg_dir_in (cfg_dir_in), .cfg_xfer_type (cfg_xfer_type),
        .cfg_dbl (cfg_dbl), .cfg_dma (cfg_dma), .cfg_maxpkt (cfg_maxpkt),
        .ep0_cont_rx (ep0_cont_rx),
        .tok_end (tok_end), .tok_ep (tok_ep), .tok_buf_rdy (tok_buf_rdy), .tok_xrun (tok_xrun),
        .xact_end (xact_end), .xact_ep (xact_ep), .rx_len (rx_len),
        .rx_short (rx_short), .rx_crc_err (rx_crc_err),
        .buf_fill (buf_fill), .buf_drain (buf_drain), .buf_rdy_evt (buf_rdy_evt),
        .dma_done (dma_done),
        .en_emp (en_emp), .en_nrdy (en_nrdy), .en_rdy (en_rdy),
        .clr_emp (clr_emp), .clr_nrdy (clr_nrdy), .clr_rdy (clr_rdy),
        .st_emp (st_emp), .st_nrdy (st_nrdy), .st_rdy (st_rdy), .irq (irq)
    );

    task automatic check(input string req, input logic [NUM_EP-1:0] act,
                         input logic [NUM_EP-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        tok_end = 0; tok_ep = 0; tok_buf_rdy = 0; tok_xrun = 0;
        xact_end = 0; xact_ep = 0; rx_len = 0; rx_short = 0; rx_crc_err = 0;
        buf_fill = 0; buf_drain = 0; buf_rdy_evt = 0; dma_done = 0;
        clr_emp = 0; clr_nrdy = 0; clr_rdy = 0;
    endtask

    // Ends the cycle opened by the caller; status is visible on return.
    task automatic step();
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_emp = '1; clr_nrdy = '1; clr_rdy = '1;
        step();
    endtask

    task automatic tok(input int ep, input logic brdy, input logic xrun);
        @(negedge clk);
        tok_end = 1; tok_ep = 3'(ep); tok_buf_rdy = brdy; tok_xrun = xrun;
        step();
    endtask

    task automatic xact(input int ep, input int len, input logic shrt, input logic crc);
        @(negedge clk);
        xact_end = 1; xact_ep = 3'(ep); rx_len = LEN_W'(len); rx_short = shrt; rx_crc_err = crc;
        step();
    endtask

    task automatic t_reset();
        check("R1 st_emp",  st_emp,  '0);
        check("R1 st_nrdy", st_nrdy, '0);
        check("R1 st_rdy",  st_rdy,  '0);
        check("R1 irq",     {5'b0, irq}, '0);
    endtask

    task automatic t_in_drain();
        clear_all();
        @(negedge clk); buf_fill[1] = 1; step();
        @(negedge clk); buf_drain[1] = 1; step();
        check("R2 single drained", st_emp, 6'b000010);
        clear_all();
        @(negedge clk); buf_fill[2] = 1; step();
        @(negedge clk); buf_fill[2] = 1; step();
        @(negedge clk); buf_drain[2] = 1; step();
        check("R2 double one half left", st_emp, 6'b000000);
        @(negedge clk); buf_drain[2] = 1; step();
        check("R2 double both drained", st_emp, 6'b000100);
    endtask

    task automatic t_oversize();
        clear_all();
        xact(3, 65, 0, 0);
        check("R3 oversize", st_emp, 6'b001000);
        clear_all();
        xact(3, 64, 0, 0);
        check("R3 at max", st_emp, 6'b000000);
    endtask

    task automatic t_nrdy();
        clear_all();
        tok(3, 0, 0);
        check("R4 not ready", st_nrdy, 6'b001000);
        clear_all();
        tok(3, 1, 0);
        check("R4 ready token", st_nrdy, 6'b000000);
    endtask

    task automatic t_iso();
        clear_all();
        tok(4, 1, 1);
        check("R5 iso xrun", st_nrdy, 6'b010000);
        clear_all();
        tok(4, 0, 0);
        check("R5 iso no xrun", st_nrdy, 6'b000000);
        xact(4, 10, 0, 1);
        check("R5 iso crc", st_nrdy, 6'b010000);
    endtask

    task automatic t_ep0();
        clear_all();
        cfg_dir_in[0] = 0;
        @(negedge clk); buf_rdy_evt[0] = 1; step();
        check("R6 ep0 rx ready", st_rdy, 6'b000001);
        clear_all();
        cfg_dir_in[0] = 1;
        @(negedge clk); buf_rdy_evt[0] = 1; step();
        check("R6 ep0 tx ignored", st_rdy, 6'b000000);
        cfg_dir_in[0] = 0;
    endtask

    task automatic t_cont();
        clear_all();
        ep0_cont_rx = 1;
        xact(0, 64, 0, 0); xact(0, 64, 0, 0); xact(0, 64, 0, 0);
        check("R7 below 255", st_rdy, 6'b000000);
        xact(0, 64, 0, 0);
        check("R7 total reached", st_rdy, 6'b000001);
        clear_all();
        @(negedge clk); buf_rdy_evt[0] = 1; step();
        check("R7 rdy strobe ignored", st_rdy, 6'b000000);
        xact(0, 10, 1, 0);
        check("R7 short packet", st_rdy, 6'b000001);
        ep0_cont_rx = 0;
    endtask

    task automatic t_cpu_rdy();
        clear_all();
        @(negedge clk); buf_rdy_evt[1] = 1; buf_rdy_evt[3] = 1; step();
        check("R8 cpu ready", st_rdy, 6'b001010);
    endtask

    task automatic t_dma();
        clear_all();
        @(negedge clk); dma_done[5] = 1; step();
        check("R9 done without short", st_rdy, 6'b000000);
        xact(5, 5, 1, 0);
        check("R9 short only", st_rdy, 6'b000000);
        @(negedge clk); dma_done[5] = 1; step();
        check("R9 short then done", st_rdy, 6'b100000);
        clear_all();
        cfg_dma[1] = 1;
        @(negedge clk); buf_rdy_evt[1] = 1; dma_done[1] = 1; step();
        check("R9 dma in silent", st_rdy, 6'b000000);
        cfg_dma[1] = 0;
    endtask

    task automatic t_w1c();
        clear_all();
        @(negedge clk); buf_rdy_evt[3] = 1; step();
        @(negedge clk); buf_rdy_evt[3] = 1; clr_rdy[3] = 1; step();
        check("R10 set beats clear", st_rdy, 6'b001000);
        @(negedge clk); clr_rdy[3] = 1; step();
        check("R10 clear alone", st_rdy, 6'b000000);
    endtask

    task automatic t_irq();
        clear_all();
        en_rdy = 6'b001000;
        @(negedge clk); buf_rdy_evt[1] = 1; step();
        check("R11 masked pending", {5'b0, irq}, 6'd0);
        @(negedge clk); buf_rdy_evt[3] = 1; step();
        check("R11 enabled pending", {5'b0, irq}, 6'd1);
        clear_all();
        check("R11 after clear", {5'b0, irq}, 6'd0);
        en_rdy = '0;
    endtask

    initial begin
        idle_inputs();
        rst_n = 0;
        cfg_dir_in    = 6'b000110;                 // EP1, EP2 IN
        cfg_xfer_type = 12'b00_10_00_00_00_00;     // EP4 isochronous
        cfg_dbl       = 6'b000100;                 // EP2 double
        cfg_dma       = 6'b100000;                 // EP5 DMA
        cfg_maxpkt    = {NUM_EP{11'd64}};
        ep0_cont_rx   = 0;
        en_emp = 0; en_nrdy = 0; en_rdy = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_in_drain();
        t_oversize();
        t_nrdy();
        t_iso();
        t_ep0();
        t_cont();
        t_cpu_rdy();
        t_dma();
        t_w1c();
        t_irq();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #80000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule